// File: doc/BRIEF.md
# Parallel I/O Port with Sticky Edge Interrupt

This block is a general-purpose parallel port that a small soft processor reaches through a word-addressed register bus. Each pin can be an output or an input, set per bit by a direction register. Input pins pass through a two-flop synchroniser. A selectable edge on a synchronised input sets a sticky flag in a capture register.

A per-bit enable register decides which capture flags may raise the single level interrupt request. Software reads the capture register to find the pin that fired. For example, a value of 1 means pin 0 and a value of 4 means pin 2. Software then writes the capture register to clear it, and the request drops.

A build parameter fixes the port kind: output-only, input-only with interrupts, or bidirectional. A second parameter picks the active edge: rising (the default), falling or both.

The bus has no back-pressure. A request is accepted in the cycle where `bus_sel` is high. The read answer appears with `bus_rvalid` one cycle later, and there is no stall and no ready signal.

Top module: `pio_port`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and `pin_oe` is 0.
- R2: Word address 0 selects the data register, 1 the direction register, 2 the interrupt-enable register and 3 the capture register. A read issued in one cycle returns its value with `bus_rvalid` high in the next cycle. Direction and enable read back as written.
- R3: `pin_oe` equals the direction register (1 = drive). `pin_out` equals the last value written to the data register.
- R4: A read of the data register returns the output register for bits whose direction is 1. For bits whose direction is 0 it returns the synchronised pin, which follows a pin change after two clock edges.
- R5: With the default rising-edge setting, a 0-to-1 change on a pin sets its capture bit at the third clock edge after the change. A 1-to-0 change sets nothing.
- R6: A set capture bit stays set until cleared, whatever the pin does afterwards.
- R7: `irq` is 1 exactly when some capture bit and the matching enable bit are both 1. It holds as a level, and a captured bit whose enable is 0 raises no request.
- R8: Any write to address 3 clears all capture bits at that clock edge, and `irq` falls with it.
- R9: An edge detected in the same cycle as a clearing write leaves its capture bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read answer present |
| pin_in | input | WIDTH | Pin values from the pads |
| pin_out | output | WIDTH | Values to drive onto the pads |
| pin_oe | output | WIDTH | Per-pin drive enable |
| irq | output | 1 | Level interrupt request |

## Verification
The bench applies single rising edges on enabled pins and on masked pins. This separates capture from request generation. It then applies falling edges on pins that are already captured, which shows that edge polarity is honoured and that flags are sticky. A mixed direction pattern with different pin and output values tells apart the two sources the data read can select per bit. An edge timed into the very cycle of a clearing write shows whether the edge or the clear wins.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_MASK = 2'd2,
    REG_CAP  = 2'd3
  } reg_sel_e;

  localparam int KIND_OUT   = 0;
  localparam int KIND_IN    = 1;
  localparam int KIND_BIDIR = 2;

  localparam int EDGE_RISE = 0;
  localparam int EDGE_FALL = 1;
  localparam int EDGE_ANY  = 2;
endpackage

// File: rtl/pio_sync_edge.sv
module pio_sync_edge #(
  parameter int WIDTH     = 8,
  parameter int EDGE_MODE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] edge_o
);
  logic [WIDTH-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level_o = sync_q;

  generate
    if (EDGE_MODE == pio_pkg::EDGE_FALL) begin : g_fall
      assign edge_o = ~sync_q & prev_q;
    end else if (EDGE_MODE == pio_pkg::EDGE_ANY) begin : g_any
      assign edge_o = sync_q ^ prev_q;
    end else begin : g_rise
      assign edge_o = sync_q & ~prev_q;
    end
  endgenerate

  // An edge always reflects a change of the synchronised level
  AST_EDGE_IS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o != '0) |-> (sync_q != prev_q)); // R5
endmodule

// File: rtl/pio_capture.sv
module pio_capture #(
  parameter int WIDTH      = 8,
  parameter bit CAPTURE_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] edge_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] cap_o
);
  logic [WIDTH-1:0] cap_q;

  generate
    if (CAPTURE_EN) begin : g_cap
      always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else if (clr_i) cap_q <= edge_i;
        else cap_q <= cap_q | edge_i;
      end
    end else begin : g_nocap
      always_ff @(posedge clk) cap_q <= '0;
    end
  endgenerate

  assign cap_o = cap_q;

  AST_CAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((cap_q & $past(cap_q)) == $past(cap_q))); // R6
  AST_CAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && edge_i == '0) |=> (cap_q == '0)); // R8
  AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (CAPTURE_EN && edge_i != '0) |=> ((cap_q & $past(edge_i)) == $past(edge_i))); // R9
endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int WIDTH     = 8,
  parameter int PORT_KIND = pio_pkg::KIND_BIDIR,
  parameter int EDGE_MODE = pio_pkg::EDGE_RISE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  output logic             bus_rvalid,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic             irq
);
  import pio_pkg::*;

  localparam bit CAPTURE_EN = (PORT_KIND != KIND_OUT);

  logic [WIDTH-1:0] out_q, dir_q, mask_q, dir_eff;
  logic [WIDTH-1:0] level, edges, cap;
  logic             wr, rd, cap_clr;
  reg_sel_e         sel;

  assign sel     = reg_sel_e'(bus_addr);
  assign wr      = bus_sel & bus_we;
  assign rd      = bus_sel & ~bus_we;
  assign cap_clr = wr && (sel == REG_CAP);

  pio_sync_edge #(.WIDTH(WIDTH), .EDGE_MODE(EDGE_MODE)) sync_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_in), .level_o(level), .edge_o(edges));

  pio_capture #(.WIDTH(WIDTH), .CAPTURE_EN(CAPTURE_EN)) cap_i (
    .clk(clk), .rst_n(rst_n), .edge_i(edges), .clr_i(cap_clr), .cap_o(cap));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else if (wr) begin
      case (sel)
        REG_DATA: out_q  <= bus_wdata;
        REG_DIR:  dir_q  <= bus_wdata;
        REG_MASK: mask_q <= bus_wdata;
        default:  ;
      endcase
    end
  end

  generate
    if (PORT_KIND == KIND_IN) begin : g_in
      assign dir_eff = '0;
    end else if (PORT_KIND == KIND_OUT) begin : g_out
      assign dir_eff = '1;
    end else begin : g_bidir
      assign dir_eff = dir_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) begin
        case (sel)
          REG_DATA: bus_rdata <= (dir_eff & out_q) | (~dir_eff & level);
          REG_DIR:  bus_rdata <= dir_eff;
          REG_MASK: bus_rdata <= mask_q;
          default:  bus_rdata <= cap;
        endcase
      end
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_eff;
  assign irq     = |(cap & mask_q);

  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> bus_rvalid); // R2
  AST_OE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel == REG_DIR) |=> $stable(pin_oe)); // R3
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr && (sel == REG_CAP || sel == REG_MASK))) |=> irq); // R7
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_clr && edges == '0) |=> !irq); // R8
endmodule

// File: tb/pio_port_tb.sv
module pio_port_tb_top;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  logic bus_rvalid, irq;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  typedef struct { logic [W-1:0] val; string tag; } exp_t;
  exp_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_port #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq));

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [1:0] a, logic [W-1:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  // Driver: issue a read and push what the requirements predict
  task automatic bus_read(logic [1:0] a, logic [W-1:0] exp, string tag);
    exp_t e;
    e.val = exp; e.tag = tag;
    expq.push_back(e);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // Monitor: compare read answers in order
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (expq.size() == 0) begin
        vectors++; errors++;
        $display("FAIL R2: unexpected read answer %h expected none", bus_rdata);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(e.tag, bus_rdata, e.val);
      end
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 pin_oe", pin_oe, 8'h00);
    bus_read(2'd0, 8'h00, "R1 data");
    bus_read(2'd1, 8'h00, "R1 dir");
    bus_read(2'd2, 8'h00, "R1 mask");
    bus_read(2'd3, 8'h00, "R1 cap");
    // R2 / R3 register map and pin drive
    bus_write(2'd1, 8'h0F);
    bus_write(2'd2, 8'h05);
    bus_write(2'd0, 8'hA5);
    check("R3 pin_oe", pin_oe, 8'h0F);
    check("R3 pin_out", pin_out, 8'hA5);
    bus_read(2'd1, 8'h0F, "R2 dir readback");
    bus_read(2'd2, 8'h05, "R2 mask readback");
    // R4 mixed data read, R5 rising capture, R7 masked bits
    pin_in = 8'hF0;
    tick(2);
    bus_read(2'd0, 8'hF5, "R4 mixed data read");
    bus_read(2'd3, 8'hF0, "R5 rising capture");
    check("R7 masked no irq", {7'b0, irq}, 8'h00);
    // R5 falling ignored, R6 sticky
    pin_in = 8'h00;
    tick(3);
    bus_read(2'd3, 8'hF0, "R6 sticky after fall");
    bus_read(2'd0, 8'h05, "R4 input bits low");
    // R7 enabled pin 0
    pin_in = 8'h01;
    tick(2);
    check("R5 not yet at second edge", {7'b0, irq}, 8'h00);
    tick(1);
    check("R7 irq on bit0", {7'b0, irq}, 8'h01);
    bus_read(2'd3, 8'hF1, "R5 value 1 marks pin0");
    // R8 clear
    bus_write(2'd3, 8'h00);
    check("R8 irq drops", {7'b0, irq}, 8'h00);
    bus_read(2'd3, 8'h00, "R8 cleared");
    // R7 pin 2, level held
    pin_in = 8'h04;
    tick(3);
    tick(4);
    check("R7 irq held on bit2", {7'b0, irq}, 8'h01);
    bus_read(2'd3, 8'h04, "R7 value 4 marks pin2");
    bus_write(2'd3, 8'hFF);
    check("R8 second clear", {7'b0, irq}, 8'h00);
    // R9 edge in the clearing cycle
    pin_in = 8'h05;
    tick(2);
    bus_write(2'd3, 8'h00);
    check("R9 edge kept irq", {7'b0, irq}, 8'h01);
    bus_read(2'd3, 8'h01, "R9 edge kept cap");
    tick(3);
    check("R2 all reads answered", W'(expq.size()), 8'h00);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      vectors++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule